// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit collects the four interrupt causes of an asynchronous serial port: receiver line errors, a received character waiting, an empty transmit holding register and a change on the modem inputs. Each cause is latched as a pending flag. A four-bit enable register masks the pending flags. The highest-priority cause that is both pending and enabled is reported through an identification read value, and a single interrupt line is driven while any such cause is present.

The rest of the port supplies single-cycle strobes: error and delta events that raise causes, and the bus accesses whose side effects clear them. A cause is cleared by reading the line status, reading the receive buffer, writing the holding register, reading the identification value while it names the transmitter, or reading the modem status. The identification and enable read values are combinational views of registered state. They are valid in the same cycle as the read strobe.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable read value is 0x00. A write stores data bits 3:0, where bit 0 enables received data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. Bits 7:4 always read 0.
- R2: Identification bit 0 is 1 when no enabled cause is pending and 0 otherwise. With nothing pending the value reads 0x01, including after reset. Bits 7:3 always read 0.
- R3: Identification bits 2:1 name the reported cause: 00 line status, 01 received data, 10 transmit empty, 11 modem status. Priority runs in that order, highest first, and only the highest enabled pending cause is reported.
- R4: Any bit of the line error event input raises the line-status cause. A line-status read clears it.
- R5: The received-data strobe raises the received-data cause. A receive-buffer read clears it.
- R6: A rising edge of the transmit-empty level raises the transmit-empty cause. A holding-register write clears it.
- R7: An identification read clears transmit-empty only when that read reports transmit-empty. A read that reports any other cause leaves transmit-empty pending.
- R8: An enable write that turns bit 1 from 0 to 1 while the transmit-empty level is high raises the transmit-empty cause on the next cycle.
- R9: Any bit of the modem delta event input raises the modem-status cause. A modem-status read clears it.
- R10: The interrupt output equals the inverse of identification bit 0. Disabled causes stay latched and are reported as soon as they are enabled.
- R11: When a raising event and a clearing strobe for the same cause fall in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read value |
| id_rd | input | 1 | Identification read strobe |
| id_rdata | output | 8 | Identification read value |
| line_err_evt | input | 4 | Overrun, parity, framing and break event pulses |
| line_stat_rd | input | 1 | Line status read strobe |
| rx_char_evt | input | 1 | Character received pulse |
| rx_buf_rd | input | 1 | Receive buffer read strobe |
| tx_hold_empty | input | 1 | Transmit holding register empty level |
| tx_hold_wr | input | 1 | Transmit holding register write strobe |
| modem_delta_evt | input | 4 | Modem input change event pulses |
| modem_stat_rd | input | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request |

## Verification
A pending flag stuck at the wrong value appears one cycle after the event or strobe that should have moved it. It shows up as a wrong cause code or a wrong level on irq, but only while the corresponding enable bit is set and no higher cause hides it. For that reason the sweep loads every combination of pending causes under every enable mask. A broken priority order or enable mapping then produces a wrong identification value on the first vector that exposes it. Directed sequences cover the side-effect clears, the edge-triggered transmit source and the set-over-clear rule. For those, a wrong flag is visible one cycle later.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int SRC_N = 4;

    // Index order is the priority order and also the reported cause code.
    localparam int SRC_LS   = 0;
    localparam int SRC_RX   = 1;
    localparam int SRC_THRE = 2;
    localparam int SRC_MS   = 3;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_empty,
    output logic [SRC_N-1:0]  en,
    output logic              thre_arm
);
    typedef struct packed {
        logic [SRC_N-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        thre_arm = 1'b0;
        if (wr) begin
            st_d.en  = wdata[SRC_N-1:0];
            // Enable bit 1 governs the transmit-empty cause.
            thre_arm = wdata[1] && !st_q.en[1] && tx_empty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
#(
    parameter int LS_EVT_W = 4,
    parameter int MS_EVT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LS_EVT_W-1:0] ls_evt,
    input  logic                ls_clr,
    input  logic                rx_evt,
    input  logic                rx_clr,
    input  logic                tx_empty,
    input  logic                thre_arm,
    input  logic                thre_clr,
    input  logic [MS_EVT_W-1:0] ms_evt,
    input  logic                ms_clr,
    output src_vec_t            pend
);
    typedef struct packed {
        src_vec_t pend;
        logic     tx_prev;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic        tx_rise;

    always_comb begin
        st_d       = st_q;
        tx_rise    = tx_empty && !st_q.tx_prev;
        st_d.tx_prev = tx_empty;

        // Clears first; a same-cycle raise then overrides.
        if (ls_clr)   st_d.pend[SRC_LS]   = 1'b0;
        if (rx_clr)   st_d.pend[SRC_RX]   = 1'b0;
        if (thre_clr) st_d.pend[SRC_THRE] = 1'b0;
        if (ms_clr)   st_d.pend[SRC_MS]   = 1'b0;

        if (|ls_evt)             st_d.pend[SRC_LS]   = 1'b1;
        if (rx_evt)              st_d.pend[SRC_RX]   = 1'b1;
        if (tx_rise || thre_arm) st_d.pend[SRC_THRE] = 1'b1;
        if (|ms_evt)             st_d.pend[SRC_MS]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend    <= '0;
            st_q.tx_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    localparam int ID_W = $clog2(SRC_N)
) (
    input  src_vec_t         pend,
    input  logic [SRC_N-1:0] en,
    output logic [ID_W-1:0]  cause,
    output logic             any
);
    src_vec_t act;

    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_mask
            // Enable bit positions differ from priority positions.
            localparam int EN_BIT = (g == SRC_LS)   ? 2 :
                                    (g == SRC_RX)   ? 0 :
                                    (g == SRC_THRE) ? 1 : 3;
            assign act[g] = pend[g] && en[EN_BIT];
        end
    endgenerate

    always_comb begin
        cause = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (act[i]) cause = ID_W'(i);
        end
        any = |act;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LS_EVT_W = 4,
    parameter int MS_EVT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_wr,
    input  logic [DATA_W-1:0]   en_wdata,
    output logic [DATA_W-1:0]   en_rdata,
    input  logic                id_rd,
    output logic [DATA_W-1:0]   id_rdata,
    input  logic [LS_EVT_W-1:0] line_err_evt,
    input  logic                line_stat_rd,
    input  logic                rx_char_evt,
    input  logic                rx_buf_rd,
    input  logic                tx_hold_empty,
    input  logic                tx_hold_wr,
    input  logic [MS_EVT_W-1:0] modem_delta_evt,
    input  logic                modem_stat_rd,
    output logic                irq
);
    localparam int ID_W  = $clog2(SRC_N);
    localparam int PAD_W = DATA_W - ID_W - 1;

    logic [SRC_N-1:0] en;
    logic             thre_arm;
    src_vec_t         pend;
    logic [ID_W-1:0]  cause;
    logic             any;
    logic             thre_ack;

    uart_irq_enable #(.DATA_W(DATA_W)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (en_wr),
        .wdata    (en_wdata),
        .tx_empty (tx_hold_empty),
        .en       (en),
        .thre_arm (thre_arm)
    );

    assign thre_ack = id_rd && any && (cause == ID_W'(SRC_THRE));

    uart_irq_pending #(.LS_EVT_W(LS_EVT_W), .MS_EVT_W(MS_EVT_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ls_evt   (line_err_evt),
        .ls_clr   (line_stat_rd),
        .rx_evt   (rx_char_evt),
        .rx_clr   (rx_buf_rd),
        .tx_empty (tx_hold_empty),
        .thre_arm (thre_arm),
        .thre_clr (tx_hold_wr || thre_ack),
        .ms_evt   (modem_delta_evt),
        .ms_clr   (modem_stat_rd),
        .pend     (pend)
    );

    uart_irq_prio u_prio (
        .pend  (pend),
        .en    (en),
        .cause (cause),
        .any   (any)
    );

    assign en_rdata = {{(DATA_W-SRC_N){1'b0}}, en};
    assign id_rdata = {{PAD_W{1'b0}}, cause, ~any};
    assign irq      = any;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int DATA_W   = 8,
    parameter int LS_EVT_W = 4,
    parameter int MS_EVT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_wr,
    input logic [DATA_W-1:0]   en_rdata,
    input logic [DATA_W-1:0]   id_rdata,
    input logic [LS_EVT_W-1:0] line_err_evt,
    input logic                line_stat_rd,
    input logic                rx_char_evt,
    input logic                rx_buf_rd,
    input logic                tx_hold_empty,
    input logic                tx_hold_wr,
    input logic [MS_EVT_W-1:0] modem_delta_evt,
    input logic                modem_stat_rd,
    input logic                irq
);
    AST_EN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_rdata[DATA_W-1:4] == '0); // R1

    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        id_rdata[DATA_W-1:3] == '0); // R2

    AST_IRQ_MATCH_ID: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !id_rdata[0]); // R10

    AST_LS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stat_rd && line_err_evt == '0) |=> id_rdata[2:0] != 3'b000); // R4

    AST_RX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf_rd && !rx_char_evt) |=> id_rdata[2:0] != 3'b010); // R5

    AST_THRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold_wr && !en_wr && $stable(tx_hold_empty)) |=> id_rdata[2:0] != 3'b100); // R6

    AST_MS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_stat_rd && modem_delta_evt == '0) |=> id_rdata[2:0] != 3'b110); // R9
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .DATA_W(DATA_W), .LS_EVT_W(LS_EVT_W), .MS_EVT_W(MS_EVT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_wr           (en_wr),
    .en_rdata        (en_rdata),
    .id_rdata        (id_rdata),
    .line_err_evt    (line_err_evt),
    .line_stat_rd    (line_stat_rd),
    .rx_char_evt     (rx_char_evt),
    .rx_buf_rd       (rx_buf_rd),
    .tx_hold_empty   (tx_hold_empty),
    .tx_hold_wr      (tx_hold_wr),
    .modem_delta_evt (modem_delta_evt),
    .modem_stat_rd   (modem_stat_rd),
    .irq             (irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic [7:0] en_rdata;
    logic       id_rd = 1'b0;
    logic [7:0] id_rdata;
    logic [3:0] line_err_evt = '0;
    logic       line_stat_rd = 1'b0;
    logic       rx_char_evt = 1'b0;
    logic       rx_buf_rd = 1'b0;
    logic       tx_hold_empty = 1'b1;
    logic       tx_hold_wr = 1'b0;
    logic [3:0] modem_delta_evt = '0;
    logic       modem_stat_rd = 1'b0;
    logic       irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .id_rd(id_rd), .id_rdata(id_rdata),
        .line_err_evt(line_err_evt), .line_stat_rd(line_stat_rd),
        .rx_char_evt(rx_char_evt), .rx_buf_rd(rx_buf_rd),
        .tx_hold_empty(tx_hold_empty), .tx_hold_wr(tx_hold_wr),
        .modem_delta_evt(modem_delta_evt), .modem_stat_rd(modem_stat_rd),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Advance one edge, then drop all strobes.
    task automatic tick();
        @(posedge clk);
        #1;
        en_wr = 1'b0; id_rd = 1'b0; line_err_evt = '0; line_stat_rd = 1'b0;
        rx_char_evt = 1'b0; rx_buf_rd = 1'b0; tx_hold_wr = 1'b0;
        modem_delta_evt = '0; modem_stat_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_id(input logic [3:0] m, input logic [3:0] e);
        // m: bit0 line, bit1 rx, bit2 thre, bit3 modem; e: ier bit mapping per R1
        logic [3:0] a;
        a[0] = m[0] & e[2];
        a[1] = m[1] & e[0];
        a[2] = m[2] & e[1];
        a[3] = m[3] & e[3];
        if (a[0]) return 8'h00;
        if (a[1]) return 8'h02;
        if (a[2]) return 8'h04;
        if (a[3]) return 8'h06;
        return 8'h01;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset enable", en_rdata, 8'h00);
        chk("R2 reset id", id_rdata, 8'h01);
        chk("R10 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R1: upper write bits are dropped
        en_wr = 1'b1; en_wdata = 8'hF5; tick();
        chk("R1 enable store", en_rdata, 8'h05);

        // Sweep: every pending mask under every enable mask (R3, R4, R5, R6, R9, R10)
        for (int e = 0; e < 16; e++) begin
            for (int m = 0; m < 16; m++) begin
                en_wr = 1'b1; en_wdata = 8'(e); tick();
                line_stat_rd = 1'b1; rx_buf_rd = 1'b1; modem_stat_rd = 1'b1;
                tx_hold_wr = 1'b1; tx_hold_empty = 1'b0; tick();
                line_err_evt = m[0] ? 4'(1 << (m % 4)) : 4'h0;
                rx_char_evt = m[1];
                tx_hold_empty = m[2];
                modem_delta_evt = m[3] ? 4'(8 >> (e % 4)) : 4'h0;
                tick();
                chk("R3 sweep id", id_rdata, exp_id(4'(m), 4'(e)));
                chk("R10 sweep irq", {7'b0, irq}, {7'b0, exp_id(4'(m), 4'(e)) != 8'h01});
                chk("R1 sweep enable", en_rdata, 8'(e));
            end
        end

        // Clear everything, enable all, tx level ends high without a pending edge
        en_wr = 1'b1; en_wdata = 8'h0F; tx_hold_empty = 1'b1; tick();
        line_stat_rd = 1'b1; rx_buf_rd = 1'b1; modem_stat_rd = 1'b1; tx_hold_wr = 1'b1; tick();
        chk("R2 all cleared", id_rdata, 8'h01);

        // R4 / R5 / R9 individual clears
        line_err_evt = 4'b1000; tick();
        chk("R4 break raises line", id_rdata, 8'h00);
        line_stat_rd = 1'b1; tick();
        chk("R4 line read clears", id_rdata, 8'h01);
        rx_char_evt = 1'b1; tick();
        chk("R5 rx raises", id_rdata, 8'h02);
        rx_buf_rd = 1'b1; tick();
        chk("R5 buffer read clears", id_rdata, 8'h01);
        modem_delta_evt = 4'b0100; tick();
        chk("R9 delta raises", id_rdata, 8'h06);
        modem_stat_rd = 1'b1; tick();
        chk("R9 modem read clears", id_rdata, 8'h01);

        // R6: rising edge raises, write clears
        tx_hold_empty = 1'b0; tick();
        tx_hold_empty = 1'b1; tick();
        chk("R6 edge raises", id_rdata, 8'h04);
        tx_hold_wr = 1'b1; tick();
        chk("R6 write clears", id_rdata, 8'h01);

        // R7: read while rx reported leaves thre; read while thre reported clears
        tx_hold_empty = 1'b0; rx_char_evt = 1'b1; tick();
        tx_hold_empty = 1'b1; tick();
        chk("R7 rx over thre", id_rdata, 8'h02);
        id_rd = 1'b1; tick();
        chk("R7 id read keeps rx", id_rdata, 8'h02);
        rx_buf_rd = 1'b1; tick();
        chk("R7 thre survived read", id_rdata, 8'h04);
        id_rd = 1'b1; tick();
        chk("R7 id read clears thre", id_rdata, 8'h01);

        // R8: enabling transmit-empty while level high raises at once
        en_wr = 1'b1; en_wdata = 8'h0D; tick();
        chk("R8 disabled quiet", id_rdata, 8'h01);
        en_wr = 1'b1; en_wdata = 8'h0F; tick();
        chk("R8 enable raises", id_rdata, 8'h04);
        tx_hold_wr = 1'b1; tick();
        en_wr = 1'b1; en_wdata = 8'h0F; tick();
        chk("R8 re-enable no raise", id_rdata, 8'h01);

        // R10: latched while disabled, reported once enabled
        en_wr = 1'b1; en_wdata = 8'h00; tick();
        modem_delta_evt = 4'b0001; tick();
        chk("R10 masked irq", {7'b0, irq}, 8'h00);
        en_wr = 1'b1; en_wdata = 8'h08; tick();
        chk("R10 late enable", id_rdata, 8'h06);
        chk("R10 irq high", {7'b0, irq}, 8'h01);
        en_wr = 1'b1; en_wdata = 8'h0F; modem_stat_rd = 1'b1; tick();

        // R11: raise and clear in the same cycle leave the cause pending
        line_err_evt = 4'b0010; line_stat_rd = 1'b1; tick();
        chk("R11 line set wins", id_rdata, 8'h00);
        line_stat_rd = 1'b1; tick();
        rx_char_evt = 1'b1; rx_buf_rd = 1'b1; tick();
        chk("R11 rx set wins", id_rdata, 8'h02);
        rx_buf_rd = 1'b1; tick();
        tx_hold_empty = 1'b0; tick();
        tx_hold_empty = 1'b1; tx_hold_wr = 1'b1; tick();
        chk("R11 thre set wins", id_rdata, 8'h04);
        tx_hold_wr = 1'b1; modem_delta_evt = 4'b1000; modem_stat_rd = 1'b1; tick();
        chk("R11 modem set wins", id_rdata, 8'h06);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule